// File: doc/BRIEF.md
# Output Pin Override Unit

The unit sits between a set of internally generated output values and the chip pins that carry them, such as an external reset line, a flash write-protect line and key pass-through lines. For each pin, software may replace the internal value with a forced value. Forcing needs two things: the pin's override enable bit, and permission for the specific value requested. There is one permission bit that allows a forced 0 and another that allows a forced 1. If the requested value is not permitted, the pin keeps its internal value.

Configuration arrives over a single write port. A 3-bit select picks one of six pin-wide registers, and the write data holds one bit per pin. Two optional inversion stages are available. One flips internal values before the override mux. The other flips the final pin value. A parameter can remove both. A set of pins named by a parameter mask comes out of reset already forced low. This holds the reset and write-protect lines asserted until software releases them. The pin outputs are registered. The asynchronous reset is released synchronously.

Top module: `pin_ovr_unit`

## Requirements
- R1: While reset is applied, every pin output is 0. When reset is released, the enable register and the allow-0 register both hold HOLD_MASK. The allow-1, value and both inversion registers hold 0.
- R2: A pin whose enable bit is 0 drives its internal value, after input inversion and output inversion.
- R3: A pin with enable 1, value 1 and allow-1 set drives 1, after output inversion.
- R4: A pin with enable 1, value 0 and allow-0 set drives 0, after output inversion.
- R5: A pin with enable 1 whose requested value lacks permission drives its internal value, exactly as under R2.
- R6: Pins in HOLD_MASK stay low for as long as software leaves their configuration alone, whatever their internal values do. Writing enable 0 for such a pin releases it.
- R7: The input-inversion register (select 4) flips the internal value of each pin whose bit is set, before the override mux.
- R8: The output-inversion register (select 5) flips the final value of each pin whose bit is set, forced values included.
- R9: A configuration write or an internal value change becomes visible on the pins exactly one clock edge after the edge that captures it. Until then the pins keep their previous value.
- R10: Register selects are 0 enable, 1 allow-0, 2 allow-1, 3 value, 4 input inversion and 5 output inversion. A write with select 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Register select (see R10) |
| cfg_wdata_i | input | NUM_PINS | Write data, one bit per pin |
| pin_in_i | input | NUM_PINS | Internal per-pin values |
| pin_o | output | NUM_PINS | Registered pin outputs |

## Verification
The bench builds the unit with eight pins and HOLD_MASK set to pins 0 and 1, with inversion enabled. Every register select is reachable with this build, including the two unused codes. Forced and unforced pins sit side by side in the same vector, so a pin leaking into its neighbour shows up. Having held and free pins together lets the bench show that the held lines ignore their internal values while the free lines pass them through, both after reset and across a mid-run reset.

// File: rtl/pin_ovr_pkg.sv
package pin_ovr_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_EN      = 3'd0,
    SEL_ALLOW0  = 3'd1,
    SEL_ALLOW1  = 3'd2,
    SEL_VALUE   = 3'd3,
    SEL_INV_IN  = 3'd4,
    SEL_INV_OUT = 3'd5
  } cfg_sel_e;
endpackage

// File: rtl/pin_ovr_rst_sync.sv
module pin_ovr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pin_ovr_cfg_regs.sv
module pin_ovr_cfg_regs
  import pin_ovr_pkg::*;
#(
  parameter int unsigned         NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] HOLD_MASK = '0,
  parameter bit                  INVERT_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] en_q,
  output logic [NUM_PINS-1:0] allow0_q,
  output logic [NUM_PINS-1:0] allow1_q,
  output logic [NUM_PINS-1:0] val_q,
  output logic [NUM_PINS-1:0] inv_in_q,
  output logic [NUM_PINS-1:0] inv_out_q
);
  cfg_sel_e sel;
  logic wr_en, wr_a0, wr_a1, wr_val;
  logic [NUM_PINS-1:0] en_d, allow0_d, allow1_d, val_d;

  assign sel = cfg_sel_e'(sel_i);

  always_comb begin
    wr_en  = we_i && (sel == SEL_EN);
    wr_a0  = we_i && (sel == SEL_ALLOW0);
    wr_a1  = we_i && (sel == SEL_ALLOW1);
    wr_val = we_i && (sel == SEL_VALUE);
  end

  always_comb begin
    en_d     = en_q;
    allow0_d = allow0_q;
    allow1_d = allow1_q;
    val_d    = val_q;
    if (wr_en)  en_d     = wdata_i;
    if (wr_a0)  allow0_d = wdata_i;
    if (wr_a1)  allow1_d = wdata_i;
    if (wr_val) val_d    = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= HOLD_MASK;
      allow0_q <= HOLD_MASK;
      allow1_q <= '0;
      val_q    <= '0;
    end else begin
      en_q     <= en_d;
      allow0_q <= allow0_d;
      allow1_q <= allow1_d;
      val_q    <= val_d;
    end
  end

  generate
    if (INVERT_EN) begin : g_inv
      logic wr_ii, wr_io;
      logic [NUM_PINS-1:0] inv_in_d, inv_out_d;

      always_comb begin
        wr_ii     = we_i && (sel == SEL_INV_IN);
        wr_io     = we_i && (sel == SEL_INV_OUT);
        inv_in_d  = wr_ii ? wdata_i : inv_in_q;
        inv_out_d = wr_io ? wdata_i : inv_out_q;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          inv_in_q  <= '0;
          inv_out_q <= '0;
        end else begin
          inv_in_q  <= inv_in_d;
          inv_out_q <= inv_out_d;
        end
      end
    end else begin : g_noinv
      assign inv_in_q  = '0;
      assign inv_out_q = '0;
    end
  endgenerate
endmodule

// File: rtl/pin_ovr_lane.sv
module pin_ovr_lane (
  input  logic in_i,
  input  logic en_i,
  input  logic allow0_i,
  input  logic allow1_i,
  input  logic val_i,
  input  logic inv_in_i,
  input  logic inv_out_i,
  output logic out_o
);
  logic permitted;
  logic force_sel;
  logic pre_inv;

  always_comb begin
    permitted = val_i ? allow1_i : allow0_i;
    force_sel = en_i && permitted;
    pre_inv   = force_sel ? val_i : (in_i ^ inv_in_i);
    out_o     = pre_inv ^ inv_out_i;
  end
endmodule

// File: rtl/pin_ovr_unit.sv
module pin_ovr_unit
  import pin_ovr_pkg::*;
#(
  parameter int unsigned         NUM_PINS  = 8,
  parameter logic [NUM_PINS-1:0] HOLD_MASK = 'b11,
  parameter bit                  INVERT_EN = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [SEL_W-1:0]    cfg_sel_i,
  input  logic [NUM_PINS-1:0] cfg_wdata_i,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_o
);
  logic                rst_n;
  logic [NUM_PINS-1:0] en_q, allow0_q, allow1_q, val_q, inv_in_q, inv_out_q;
  logic [NUM_PINS-1:0] pin_d;
  logic [NUM_PINS-1:0] pin_q;

  pin_ovr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  pin_ovr_cfg_regs #(
    .NUM_PINS  (NUM_PINS),
    .HOLD_MASK (HOLD_MASK),
    .INVERT_EN (INVERT_EN)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .en_q      (en_q),
    .allow0_q  (allow0_q),
    .allow1_q  (allow1_q),
    .val_q     (val_q),
    .inv_in_q  (inv_in_q),
    .inv_out_q (inv_out_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    pin_ovr_lane u_lane (
      .in_i      (pin_in_i[i]),
      .en_i      (en_q[i]),
      .allow0_i  (allow0_q[i]),
      .allow1_i  (allow1_q[i]),
      .val_i     (val_q[i]),
      .inv_in_i  (inv_in_q[i]),
      .inv_out_i (inv_out_q[i]),
      .out_o     (pin_d[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/pin_ovr_unit_chk.sv
module pin_ovr_unit_chk #(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_n,
  input logic                cfg_we_i,
  input logic [2:0]          cfg_sel_i,
  input logic [NUM_PINS-1:0] pin_in_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] en_q,
  input logic [NUM_PINS-1:0] allow0_q,
  input logic [NUM_PINS-1:0] allow1_q,
  input logic [NUM_PINS-1:0] val_q,
  input logic [NUM_PINS-1:0] inv_in_q,
  input logic [NUM_PINS-1:0] inv_out_q
);
  always @(posedge clk_i) begin
    if (rst_n === 1'b0) begin
      a_r1_reset_low: assert (pin_o == '0);
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    a_r2_follow_internal: assert property (@(posedge clk_i) disable iff (!rst_n)
      !en_q[i] |=> pin_o[i] == ($past(pin_in_i[i]) ^ $past(inv_in_q[i]) ^ $past(inv_out_q[i])));

    a_r3_force_high: assert property (@(posedge clk_i) disable iff (!rst_n)
      (en_q[i] && val_q[i] && allow1_q[i]) |=> pin_o[i] == !$past(inv_out_q[i]));

    a_r4_force_low: assert property (@(posedge clk_i) disable iff (!rst_n)
      (en_q[i] && !val_q[i] && allow0_q[i]) |=> pin_o[i] == $past(inv_out_q[i]));

    a_r5_not_permitted: assert property (@(posedge clk_i) disable iff (!rst_n)
      (en_q[i] && (val_q[i] ? !allow1_q[i] : !allow0_q[i]))
        |=> pin_o[i] == ($past(pin_in_i[i]) ^ $past(inv_in_q[i]) ^ $past(inv_out_q[i])));
  end

  a_r10_bad_sel_ignored: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg_we_i && cfg_sel_i > 3'd5) |=> ($stable(en_q) && $stable(allow0_q) && $stable(allow1_q)
      && $stable(val_q) && $stable(inv_in_q) && $stable(inv_out_q)));
endmodule

bind pin_ovr_unit pin_ovr_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .cfg_we_i  (cfg_we_i),
  .cfg_sel_i (cfg_sel_i),
  .pin_in_i  (pin_in_i),
  .pin_o     (pin_o),
  .en_q      (en_q),
  .allow0_q  (allow0_q),
  .allow1_q  (allow1_q),
  .val_q     (val_q),
  .inv_in_q  (inv_in_q),
  .inv_out_q (inv_out_q)
);

// File: tb/tb_pin_ovr_unit.sv
`timescale 1ns/1ps
module tb_pin_ovr_unit;
  localparam int unsigned N = 8;
  localparam logic [N-1:0] HOLD = 8'h03;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         cfg_we;
  logic [2:0]   cfg_sel;
  logic [N-1:0] cfg_wdata;
  logic [N-1:0] pin_in;
  logic [N-1:0] pin_o;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  logic [N-1:0] sh_en, sh_a0, sh_a1, sh_val, sh_ii, sh_io;

  always #2 clk = ~clk;

  pin_ovr_unit #(.NUM_PINS(N), .HOLD_MASK(HOLD), .INVERT_EN(1'b1)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_wdata_i (cfg_wdata),
    .pin_in_i    (pin_in),
    .pin_o       (pin_o)
  );

  // Rows: {we, sel, wdata, pin_in}
  localparam logic [19:0] VEC [0:9] = '{
    {1'b0, 3'd0, 8'h00, 8'hA5},
    {1'b1, 3'd0, 8'h00, 8'hA5},
    {1'b1, 3'd0, 8'hF0, 8'hFF},
    {1'b1, 3'd1, 8'h30, 8'hFF},
    {1'b1, 3'd3, 8'hC0, 8'hFF},
    {1'b1, 3'd2, 8'hC0, 8'h00},
    {1'b1, 3'd4, 8'h0F, 8'h00},
    {1'b1, 3'd5, 8'h81, 8'h00},
    {1'b1, 3'd6, 8'hFF, 8'h00},
    {1'b1, 3'd7, 8'h00, 8'hFF}
  };

  function automatic logic [N-1:0] model(input logic [N-1:0] din);
    logic [N-1:0] res;
    for (int i = 0; i < N; i++) begin
      logic ok;
      ok = sh_val[i] ? sh_a1[i] : sh_a0[i];
      res[i] = ((sh_en[i] && ok) ? sh_val[i] : (din[i] ^ sh_ii[i])) ^ sh_io[i];
    end
    return res;
  endfunction

  function automatic string req_of(input logic we, input logic [2:0] sel);
    if (!we) return "R6";
    case (sel)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R3";
      3'd3: return "R5";
      3'd4: return "R7";
      3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic shadow_reset();
    sh_en = HOLD; sh_a0 = HOLD; sh_a1 = '0; sh_val = '0; sh_ii = '0; sh_io = '0;
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_row(input logic we, input logic [2:0] sel,
                         input logic [N-1:0] d, input logic [N-1:0] din);
    logic [N-1:0] prev;
    prev = model(pin_in);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; pin_in = din;
    if (we) begin
      case (sel)
        3'd0: sh_en  = d;
        3'd1: sh_a0  = d;
        3'd2: sh_a1  = d;
        3'd3: sh_val = d;
        3'd4: sh_ii  = d;
        3'd5: sh_io  = d;
        default: ;
      endcase
    end
    check("R9", pin_o, prev);
    @(negedge clk);
    check(req_of(we, sel), pin_o, model(pin_in));
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit held_bad;
    rst_ni = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0; pin_in = '0;
    shadow_reset();
    #1;
    check("R1", pin_o, '0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", pin_o, model(pin_in));

    for (int r = 0; r < 10; r++) begin
      run_row(VEC[r][19], VEC[r][18:16], VEC[r][15:8], VEC[r][7:0]);
    end

    // Mid-run reset: outputs low while held, config back to reset values.
    @(negedge clk);
    rst_ni = 1'b0;
    shadow_reset();
    pin_in = 8'hFF;
    #1;
    check("R1", pin_o, '0);
    repeat (3) @(negedge clk);
    check("R1", pin_o, '0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R6", pin_o, 8'hFC);

    // Held pins stay low for a long stretch while their inputs toggle.
    held_bad = 1'b0;
    for (int c = 0; c < 100; c++) begin
      pin_in = (c % 2 == 0) ? 8'hFF : 8'h03;
      @(negedge clk);
      if (pin_o[1:0] !== 2'b00) held_bad = 1'b1;
    end
    check("R6", {7'd0, held_bad}, 8'h00);

    // Release the reset line (pin 0) only; write-protect (pin 1) stays low.
    run_row(1'b1, 3'd0, 8'h02, 8'hFF);
    check("R6", pin_o, 8'hFD);
    // Release write-protect by forcing it to 1 with permission.
    run_row(1'b1, 3'd3, 8'h02, 8'hFF);
    run_row(1'b1, 3'd2, 8'h02, 8'hFF);
    check("R3", pin_o, 8'hFF);
    // Forced 1 under output inversion.
    run_row(1'b1, 3'd5, 8'h02, 8'hFF);
    check("R8", pin_o, 8'hFD);

    summary();
    $finish;
  end
endmodule